// File: doc/BRIEF.md
# Fractional baud tick and frame timer

This block sits beside a serial transmitter and receiver and tells them when each bit and each character time ends. The period of one bit is set by a 16-bit integer divisor and a 3-bit fraction, in cycles of a fixed reference clock (24 MHz in the intended system). The line-control byte is decoded at the same time into the frame settings that the shift logic needs: the data length, the stop-bit count, the parity mode and an infrared flag.

Software-visible registers live elsewhere. They present their current divisor, fraction and line-control values on `div_i`, `frac_i` and `lcr_i`, and they pulse `cfg_wr` for one cycle whenever any of the three is written. There is no data stream through this block. All pins are plain control and status pins, and there is no back-pressure. `word_tick` gives a character-time tick for a receive-timeout counter. It counts the start bit, the data bits and the stop bits, but not a parity bit.

Top module: `uft_frame_timer`

## Requirements
- R1: After reset, no tick is produced until a write with a nonzero divisor. The frame outputs read as 5 data bits, one stop bit, parity off (`parity` = 0) and infrared off.
- R2: While running, `bit_tick` is a one-cycle pulse repeating every P = 16*div + frac + 16 reference cycles.
- R3: After the edge that samples a `cfg_wr` with a nonzero divisor, the first `bit_tick` falls in the P-th cycle after that edge.
- R4: `data_len` equals `lcr_i[1:0] + 5` (5 to 8) as captured at the last write with a nonzero divisor.
- R5: `two_stop` equals `lcr_i[2]` from that same write.
- R6: `parity` is 0 (none) when `lcr_i[5]` is clear. When `lcr_i[5]` is set it is 2 (even), whatever `lcr_i[3]` holds. The code 1 (odd) exists in the encoding but no setting produces it. `ir_mode` equals `lcr_i[6]`.
- R7: `word_tick` is high only together with a `bit_tick`. It marks the last bit tick of every group of (data_len + stop bits + 1) bit ticks after a restart. Parity is not counted.
- R8: A write with a divisor of 0 stops both ticks and leaves all frame outputs unchanged.
- R9: Any write restarts the bit counter and the word counter from zero in the next cycle, even in the middle of a bit or a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | One-cycle pulse: a divisor, fraction or line-control write happened |
| div_i | input | 16 | Integer divisor value |
| frac_i | input | 3 | Fractional adder value |
| lcr_i | input | 8 | Line-control value |
| bit_tick | output | 1 | Pulse at the end of each bit period |
| word_tick | output | 1 | Pulse at the end of each character time |
| data_len | output | 4 | Data bits per character, 5 to 8 |
| two_stop | output | 1 | 1 selects two stop bits |
| parity | output | 2 | 0 none, 1 odd, 2 even |
| ir_mode | output | 1 | Infrared mode selected |

## Verification
The divider is tried with four divisor and fraction pairs (periods of 32, 37, 55 and 66 clocks). A fraction of zero would hide an error in the fraction adder, and different integer parts expose a wrong shift of the divisor. Each of these is paired with a line-control byte that gives a different character length (7, 8 and 10 bits). This shows whether the word tick counts stop bits and whether it wrongly counts parity. One byte sets bit 3 alone and another sets bits 3 and 5 together, which separates a parity decode driven by bit 5 from one driven by bit 3. A restart in the middle of a bit and a zero-divisor write show the reload of the counters and the hold of the frame settings.

// File: rtl/uft_pkg.sv
package uft_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_ODD  = 2'd1,
    PAR_EVEN = 2'd2
  } parity_t;

  typedef struct packed {
    logic [3:0] data_len;
    logic       two_stop;
    parity_t    parity;
    logic       ir_mode;
  } frame_cfg_t;

  // Line-control byte to frame settings.
  // Even parity follows bit 5 or bit 3; only bit 5 enables parity.
  function automatic frame_cfg_t decode_lcr(input logic [7:0] lcr);
    frame_cfg_t f;
    f.data_len = 4'd5 + {2'b00, lcr[1:0]};
    f.two_stop = lcr[2];
    if (!lcr[5])                f.parity = PAR_NONE;
    else if (lcr[5] || lcr[3])  f.parity = PAR_EVEN;
    else                        f.parity = PAR_ODD;
    f.ir_mode  = lcr[6];
    return f;
  endfunction

endpackage

// File: rtl/uft_cfg.sv
module uft_cfg
  import uft_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 3,
  parameter int PER_W  = DIV_W + 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [DIV_W-1:0] div_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [7:0]       lcr_i,
  output frame_cfg_t       cfg_o,
  output logic [PER_W-1:0] period_m1_o,
  output logic             run_o
);
  logic [PER_W-1:0] per_m1_next;
  logic             div_zero;

  assign div_zero    = (div_i == '0);
  // 16*div + frac + 16 - 1
  assign per_m1_next = PER_W'({div_i, 4'b0000}) + PER_W'(frac_i) + PER_W'(15);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_o       <= decode_lcr(8'h00);
      period_m1_o <= '0;
      run_o       <= 1'b0;
    end else if (cfg_wr) begin
      run_o <= !div_zero;
      if (!div_zero) begin
        cfg_o       <= decode_lcr(lcr_i);
        period_m1_o <= per_m1_next;
      end
    end
  end
endmodule

// File: rtl/uft_bit_div.sv
module uft_bit_div #(
  parameter int PER_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [PER_W-1:0] period_m1,
  output logic             bit_tick
);
  logic [PER_W-1:0] cnt;
  logic             at_end;

  assign at_end   = (cnt == period_m1);
  assign bit_tick = run && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (clr || !run)    cnt <= '0;
    else if (at_end)         cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/uft_word_cnt.sv
module uft_word_cnt #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bit_tick,
  input  logic [IDX_W-1:0] bits_m1,
  output logic             word_tick
);
  logic [IDX_W-1:0] idx;
  logic             last;

  assign last      = (idx >= bits_m1);
  assign word_tick = bit_tick && last;

  always_ff @(posedge clk) begin
    if (!rst_n)          idx <= '0;
    else if (clr)        idx <= '0;
    else if (bit_tick)   idx <= last ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/uft_frame_timer.sv
module uft_frame_timer
  import uft_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [7:0]        lcr_i,
  output logic              bit_tick,
  output logic              word_tick,
  output logic [3:0]        data_len,
  output logic              two_stop,
  output logic [1:0]        parity,
  output logic              ir_mode
);
  localparam int PER_W = DIV_W + 5;
  localparam int IDX_W = 4;

  frame_cfg_t       cfg;
  logic [PER_W-1:0] period_m1;
  logic             run;
  logic [IDX_W-1:0] bits_m1;

  uft_cfg #(.DIV_W(DIV_W), .FRAC_W(FRAC_W), .PER_W(PER_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
    .div_i(div_i), .frac_i(frac_i), .lcr_i(lcr_i),
    .cfg_o(cfg), .period_m1_o(period_m1), .run_o(run)
  );

  uft_bit_div #(.PER_W(PER_W)) u_bit (
    .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .run(run),
    .period_m1(period_m1), .bit_tick(bit_tick)
  );

  // start + data + stop bits, minus one; parity not counted
  assign bits_m1 = cfg.data_len + (cfg.two_stop ? 4'd2 : 4'd1);

  uft_word_cnt #(.IDX_W(IDX_W)) u_word (
    .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .bit_tick(bit_tick),
    .bits_m1(bits_m1), .word_tick(word_tick)
  );

  assign data_len = cfg.data_len;
  assign two_stop = cfg.two_stop;
  assign parity   = cfg.parity;
  assign ir_mode  = cfg.ir_mode;
endmodule

// File: rtl/uft_frame_timer_chk.sv
module uft_frame_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr,
  input logic [15:0] div_i,
  input logic [7:0]  lcr_i,
  input logic        bit_tick,
  input logic        word_tick,
  input logic [3:0]  data_len,
  input logic        two_stop,
  input logic [1:0]  parity,
  input logic        ir_mode
);
  p_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);

  p_word_with_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    word_tick |-> bit_tick);

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (!bit_tick && !word_tick));

  p_zero_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && div_i == 16'd0) |=>
      ($stable(data_len) && $stable(two_stop) && $stable(parity) && $stable(ir_mode)));

  p_dlen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && div_i != 16'd0) |=> (data_len == 4'd5 + {2'b00, $past(lcr_i[1:0])}));

  p_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && div_i != 16'd0) |=> (two_stop == $past(lcr_i[2])));

  p_no_odd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    parity != 2'd1);
endmodule

bind uft_frame_timer uft_frame_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .div_i(div_i), .lcr_i(lcr_i),
  .bit_tick(bit_tick), .word_tick(word_tick), .data_len(data_len),
  .two_stop(two_stop), .parity(parity), .ir_mode(ir_mode)
);

// File: tb/uft_frame_timer_tb.sv
module uft_frame_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [15:0] div_i = '0;
  logic [2:0]  frac_i = '0;
  logic [7:0]  lcr_i = '0;
  logic        bit_tick, word_tick, two_stop, ir_mode;
  logic [3:0]  data_len;
  logic [1:0]  parity;

  always #5 clk = ~clk;

  uft_frame_timer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .div_i(div_i), .frac_i(frac_i),
    .lcr_i(lcr_i), .bit_tick(bit_tick), .word_tick(word_tick),
    .data_len(data_len), .two_stop(two_stop), .parity(parity), .ir_mode(ir_mode)
  );

  typedef struct packed {
    int unsigned at;
    logic        word;
    logic [7:0]  tag;
  } exp_t;

  exp_t        q[$];
  int unsigned cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // Monitor: every tick must match the head of the queue (R2, R3, R7, R9)
  always @(negedge clk) begin
    if (rst_n && !done && (bit_tick || word_tick)) begin
      if (q.size() == 0) begin
        chk(1'b0, "R8 unexpected tick with nothing scheduled", int'(cyc), -1);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(bit_tick && cyc == e.at, $sformatf("R%0d bit tick time", e.tag), int'(cyc), int'(e.at));
        chk(word_tick == e.word, $sformatf("R7 word tick flag (case R%0d)", e.tag),
            int'(word_tick), int'(e.word));
      end
    end
  end

  // Driver: issue a write and schedule the ticks the requirements predict
  task automatic configure(input logic [15:0] d, input logic [2:0] f, input logic [7:0] l,
                           input int nticks, input int tag);
    int unsigned w, p, nb;
    @(negedge clk); #1;
    div_i = d; frac_i = f; lcr_i = l; cfg_wr = 1'b1;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
    q.delete();
    w = cyc;
    if (d != 0) begin
      p  = 16 * d + f + 16;
      nb = (l[1:0] + 5) + (l[2] ? 2 : 1) + 1;
      for (int k = 0; k < nticks; k++) begin
        exp_t e;
        e.at   = w + p - 1 + k * p;
        e.word = ((k % nb) == nb - 1);
        e.tag  = 8'(tag);
        q.push_back(e);
      end
    end
  endtask

  task automatic drain();
    while (q.size() != 0) @(posedge clk);
  endtask

  task automatic check_frame(input int dl, input bit ts, input int par, input bit ir, input string tag);
    chk(data_len == 4'(dl), {tag, " data_len"}, int'(data_len), dl);
    chk(two_stop == ts, {tag, " two_stop"}, int'(two_stop), int'(ts));
    chk(parity == 2'(par), {tag, " parity"}, int'(parity), par);
    chk(ir_mode == ir, {tag, " ir_mode"}, int'(ir_mode), int'(ir));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check_frame(5, 1'b0, 0, 1'b0, "R1 reset");
    chk(!bit_tick && !word_tick, "R1 ticks at reset", int'(bit_tick), 0);
    repeat (100) @(posedge clk);   // monitor flags any tick here (R1)

    // R2 R4 R5 R6: period 32, 8 data 1 stop, no parity, 10-bit word
    configure(16'd1, 3'd0, 8'h03, 20, 2);
    check_frame(8, 1'b0, 0, 1'b0, "R4 cfg A");
    drain();

    // R3 R6: period 37, 5 data 2 stop, bit5 -> even, 8-bit word
    configure(16'd1, 3'd5, 8'h24, 16, 3);
    check_frame(5, 1'b1, 2, 1'b0, "R6 cfg B");
    drain();

    // R5 R6: period 55, 7 data 2 stop, bits 3 and 5 -> even, infrared
    configure(16'd2, 3'd7, 8'h6E, 20, 5);
    check_frame(7, 1'b1, 2, 1'b1, "R5 cfg C");
    drain();

    // R6: bit 3 alone leaves parity off; period 66, 7-bit word
    configure(16'd3, 3'd2, 8'h08, 14, 6);
    check_frame(5, 1'b0, 0, 1'b0, "R6 cfg D");
    drain();

    // R9: restart in the middle of the second bit
    configure(16'd1, 3'd0, 8'h03, 50, 2);
    repeat (52) @(posedge clk);
    configure(16'd1, 3'd0, 8'h03, 12, 9);
    drain();

    // R8: zero divisor stops ticks and keeps frame settings of cfg A
    configure(16'd0, 3'd4, 8'h47, 0, 8);
    check_frame(8, 1'b0, 0, 1'b0, "R8 hold");
    repeat (300) @(posedge clk);
    @(negedge clk);
    chk(!bit_tick && !word_tick, "R8 stopped", int'(bit_tick), 0);
    check_frame(8, 1'b0, 0, 1'b0, "R8 hold later");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", int'(cyc), 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule